// File: doc/BRIEF.md
# Presettable Johnson divide-by-N counter

The block is a five-stage twisted-ring (Johnson) counter that divides its clock by a ratio chosen at run time, from 2 to 10. All five stages form one shift chain that moves toward the higher index on every rising clock edge. The value shifted into stage 0 comes from a feedback point that depends on the ratio select. An even ratio N feeds back the inverse of one stage. An odd ratio feeds back the NAND of two adjacent stages, which drops one state from the ring. Any other ratio value opens the ring, and stage 0 then takes an external serial data bit.

A jam word can be loaded into the stages, and an active-high reset clears them. Jam loads can leave the active stages in a pattern that is not a Johnson state, and mode changes can do the same. Anti-lock logic detects such a pattern and forces zeros into stage 0 until the ring is back in its proper sequence. The carry output follows the highest active stage, so it makes one rising edge per N input clocks. Several counters can be chained on it to reach ratios above 10. All pins are plain control or status pins: the block has no streaming interface and no back-pressure.

Top module: `johnson_divider`

## Requirements
- R1: On each rising clock edge with reset and preset low, stage[i] takes the old value of stage[i-1] for i = 1..4.
- R2: For an even ratio N in {2,4,6,8,10} with a legal active field, stage[0] takes the inverse of stage[N/2-1]. From reset the ring then repeats every N clocks.
- R3: Reset is asynchronous and active high. While it is high, all stages and carry read 0, and it overrides preset enable.
- R4: When preset enable is high at a rising edge and reset is low, stage[i] loads jam[i] for every i. This takes priority over counting.
- R5: For an odd ratio N in {3,5,7,9} with a legal active field, let L = (N+1)/2. Stage[0] then takes NOT(stage[L-1] AND stage[L-2]).
- R6: For a ratio value of 0, 1 or 11..15, stage[0] takes ext_data at each edge, and anti-lock does not act.
- R7: The active field is stage[L-1:0], with L = N/2 for even N and L = (N+1)/2 for odd N. If adjacent bits in this field differ at more than one place, stage[0] takes 0 at the next counting edge, whatever the ratio's feedback would give.
- R8: The carry equals stage[L-1] for ratios 2..10 and stage[4] for any other ratio value.
- R9: From reset with a fixed ratio N in 2..10, the carry rises exactly once every N clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| rst | input | 1 | Asynchronous clear, active high |
| load_en | input | 1 | Preset enable, active high, sampled at the rising edge |
| jam | input | 5 | Preset word, bit i goes to stage i |
| ratio | input | 4 | Divide ratio select, 2..10 internal, other values pick ext_data |
| ext_data | input | 1 | Serial bit for stage 0 when the ring is open |
| stage | output | 5 | Stage values, bit 0 is the first stage |
| carry | output | 1 | Divided output for cascading |

## Verification
The bench drives every ratio from a clean reset and checks the carry spacing. An off-by-one feedback tap shows up as a wrong period, and a wrong odd gating shows up as a ring that counts N+1. It jams non-Johnson patterns under even, odd and open-ring ratios. A design with anti-lock missing, or applied to the wrong field, keeps a split pattern circulating, and a design that also applies it in open-ring mode refuses a serial 1. It raises reset together with preset, and also between edges. A design that lets preset win, or that clears only on the clock edge, shows nonzero stages while reset is high.

// File: rtl/jd_pkg.sv
package jd_pkg;
  localparam int JD_STAGES = 5;

  typedef enum logic [1:0] {
    FB_EVEN = 2'd0,
    FB_ODD  = 2'd1,
    FB_EXT  = 2'd2
  } fb_kind_e;
endpackage

// File: rtl/jd_ratio_decode.sv
module jd_ratio_decode
  import jd_pkg::*;
#(
  parameter int STAGES  = JD_STAGES,
  parameter int RATIO_W = 4,
  parameter int IDX_W   = 3
) (
  input  logic [RATIO_W-1:0] ratio,
  output fb_kind_e           kind,
  output logic [IDX_W-1:0]   top_idx
);
  localparam logic [RATIO_W-1:0] MIN_R = RATIO_W'(2);
  localparam logic [RATIO_W-1:0] MAX_R = RATIO_W'(2 * STAGES);

  logic [RATIO_W-1:0] half;

  always_comb begin
    half    = (ratio - RATIO_W'(1)) >> 1;
    kind    = FB_EXT;
    top_idx = '0;
    if (ratio >= MIN_R && ratio <= MAX_R) begin
      kind    = ratio[0] ? FB_ODD : FB_EVEN;
      top_idx = half[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/jd_feedback.sv
module jd_feedback
  import jd_pkg::*;
#(
  parameter int STAGES = JD_STAGES,
  parameter int IDX_W  = 3
) (
  input  logic [STAGES-1:0] stage,
  input  fb_kind_e          kind,
  input  logic [IDX_W-1:0]  top_idx,
  input  logic              ext_data,
  output logic              d_in,
  output logic              legal,
  output logic              carry
);
  logic [STAGES-2:0] chg;
  logic [STAGES-1:0] lower;
  logic              hi;
  logic              hi2;

  for (genvar i = 0; i < STAGES - 1; i++) begin : g_chg
    assign chg[i] = (stage[i] ^ stage[i+1]) & (IDX_W'(i + 1) <= top_idx);
  end

  assign lower = {stage[STAGES-2:0], 1'b1};
  assign hi    = stage[top_idx];
  assign hi2   = lower[top_idx];
  assign legal = ($countones(chg) < 2);

  always_comb begin
    unique case (kind)
      FB_EVEN: d_in = legal & ~hi;
      FB_ODD:  d_in = legal & ~(hi & hi2);
      default: d_in = ext_data;
    endcase
  end

  assign carry = (kind == FB_EXT) ? stage[STAGES-1] : hi;
endmodule

// File: rtl/jd_stage_ring.sv
module jd_stage_ring #(
  parameter int STAGES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [STAGES-1:0] jam,
  input  logic              d_in,
  output logic [STAGES-1:0] stage
);
  logic [STAGES-1:0] q_r;
  logic [STAGES-1:0] nxt;

  for (genvar g = 0; g < STAGES; g++) begin : g_st
    if (g == 0) begin : g_head
      assign nxt[g] = d_in;
    end else begin : g_body
      assign nxt[g] = q_r[g-1];
    end

    always_ff @(posedge clk or posedge rst) begin
      if (rst)          q_r[g] <= 1'b0;
      else if (load_en) q_r[g] <= jam[g];
      else              q_r[g] <= nxt[g];
    end
  end

  assign stage = q_r;

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> stage == '0); // R3
  AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (rst)
    load_en |=> stage == $past(jam)); // R4
  AST_CHAIN_SHIFT: assert property (@(posedge clk) disable iff (rst)
    !load_en |=> stage[STAGES-1:1] == $past(stage[STAGES-2:0])); // R1
endmodule

// File: rtl/johnson_divider.sv
module johnson_divider
  import jd_pkg::*;
#(
  parameter int STAGES  = JD_STAGES,
  parameter int RATIO_W = $clog2(2 * STAGES + 1),
  parameter int IDX_W   = $clog2(STAGES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_en,
  input  logic [STAGES-1:0]  jam,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               ext_data,
  output logic [STAGES-1:0]  stage,
  output logic               carry
);
  fb_kind_e         kind;
  logic [IDX_W-1:0] top_idx;
  logic             d_in;
  logic             legal;

  jd_ratio_decode #(.STAGES(STAGES), .RATIO_W(RATIO_W), .IDX_W(IDX_W)) u_dec (
    .ratio   (ratio),
    .kind    (kind),
    .top_idx (top_idx)
  );

  jd_feedback #(.STAGES(STAGES), .IDX_W(IDX_W)) u_fb (
    .stage    (stage),
    .kind     (kind),
    .top_idx  (top_idx),
    .ext_data (ext_data),
    .d_in     (d_in),
    .legal    (legal),
    .carry    (carry)
  );

  jd_stage_ring #(.STAGES(STAGES)) u_ring (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .jam     (jam),
    .d_in    (d_in),
    .stage   (stage)
  );

  AST_EVEN_FEED: assert property (@(posedge clk) disable iff (rst)
    (!load_en && kind == FB_EVEN && legal) |=> stage[0] == !$past(stage[top_idx])); // R2
  AST_ODD_FEED: assert property (@(posedge clk) disable iff (rst)
    (!load_en && kind == FB_ODD && legal)
      |=> stage[0] == !($past(stage[top_idx]) && $past(stage[top_idx - 1'b1]))); // R5
  AST_OPEN_RING: assert property (@(posedge clk) disable iff (rst)
    (!load_en && kind == FB_EXT) |=> stage[0] == $past(ext_data)); // R6
  AST_ANTI_LOCK: assert property (@(posedge clk) disable iff (rst)
    (!load_en && kind != FB_EXT && !legal) |=> !stage[0]); // R7
endmodule

// File: tb/johnson_divider_test.sv
`timescale 1ns/1ps
module johnson_divider_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_en = 1'b0;
  logic [4:0] jam = '0;
  logic [3:0] ratio = 4'd10;
  logic       ext_data = 1'b0;
  logic [4:0] stage;
  logic       carry;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [4:0] mv = '0;
  string tag0 = "R3";

  always #2 clk = ~clk;

  johnson_divider uut (
    .clk(clk), .rst(rst), .load_en(load_en), .jam(jam),
    .ratio(ratio), .ext_data(ext_data), .stage(stage), .carry(carry)
  );

  task automatic check(input string req, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0d exp=%0d at %0t", req, what, got, exp, $time);
    end
  endtask

  function automatic int act_len(input int r);
    return (r + 1) / 2;
  endfunction

  function automatic bit internal(input int r);
    return r >= 2 && r <= 10;
  endfunction

  // behavioural reference for one rising edge
  task automatic model_edge();
    int r;
    int l;
    int changes;
    logic d;
    r = int'(ratio);
    if (rst) begin
      mv = '0; tag0 = "R3";
    end else if (load_en) begin
      mv = jam; tag0 = "R4";
    end else begin
      if (internal(r)) begin
        l = act_len(r);
        changes = 0;
        for (int i = 0; i < l - 1; i++) if (mv[i] != mv[i+1]) changes++;
        if (changes > 1) begin
          d = 1'b0; tag0 = "R7";
        end else if (r % 2 == 0) begin
          d = ~mv[l-1]; tag0 = "R2";
        end else begin
          d = ~(mv[l-1] & mv[l-2]); tag0 = "R5";
        end
      end else begin
        d = ext_data; tag0 = "R6";
      end
      mv = {mv[3:0], d};
    end
  endtask

  function automatic logic exp_carry();
    int r = int'(ratio);
    if (internal(r)) return mv[act_len(r) - 1];
    return mv[4];
  endfunction

  task automatic compare();
    check("R1", "upper stages", int'(stage[4:1]), int'(mv[4:1]));
    check(tag0, "stage0", int'(stage[0]), int'(mv[0]));
    check("R8", "carry", int'(carry), int'(exp_carry()));
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic do_reset();
    rst = 1'b1;
    #1;
    mv = '0;
    check("R3", "stages in reset", int'(stage), 0);
    check("R3", "carry in reset", int'(carry), 0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic period_run(input int r);
    int last_rise;
    logic prev;
    ratio = 4'(r);
    do_reset();
    last_rise = -1;
    prev = carry;
    for (int c = 0; c < 4 * r; c++) begin
      cyc();
      if (carry && !prev) begin
        if (last_rise >= 0) check("R9", "carry period", c - last_rise, r);
        last_rise = c;
      end
      prev = carry;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1;
    check("R3", "stages at start", int'(stage), 0);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;

    for (int r = 2; r <= 10; r++) begin
      ratio = 4'(r);
      do_reset();
      run(2 * r + 3);
      period_run(r);
    end

    // legal jam then count (R4, R2)
    ratio = 4'd10; jam = 5'b00111; load_en = 1'b1;
    cyc(); load_en = 1'b0; run(12);
    // illegal patterns, even and odd ratios (R7)
    jam = 5'b01010; load_en = 1'b1; cyc(); load_en = 1'b0; run(12);
    ratio = 4'd7; jam = 5'b00101; load_en = 1'b1; cyc(); load_en = 1'b0; run(12);
    ratio = 4'd6; jam = 5'b10010; load_en = 1'b1; cyc(); load_en = 1'b0; run(10);
    ratio = 4'd9; jam = 5'b11011; load_en = 1'b1; cyc(); load_en = 1'b0; run(12);

    // open ring (R6), no anti-lock on a split pattern
    ratio = 4'd0; jam = 5'b01010; load_en = 1'b1; cyc(); load_en = 1'b0;
    for (int i = 0; i < 14; i++) begin
      ext_data = ((i * 5 + 1) % 3) == 0;
      cyc();
    end
    ratio = 4'd15;
    for (int i = 0; i < 8; i++) begin
      ext_data = i[0];
      cyc();
    end
    ratio = 4'd1; ext_data = 1'b1; run(6);

    // ratio change while counting
    ratio = 4'd10; do_reset(); run(7);
    ratio = 4'd3; run(8);

    // reset beats preset (R3)
    ratio = 4'd8; run(5);
    jam = 5'b11111; load_en = 1'b1; rst = 1'b1;
    #1; mv = '0;
    check("R3", "reset over preset", int'(stage), 0);
    cyc();
    check("R3", "reset held with preset", int'(stage), 0);
    load_en = 1'b0; rst = 1'b0;
    run(6);

    // reset between edges (R3)
    #1; rst = 1'b1; #0.5; mv = '0;
    check("R3", "async clear", int'(stage), 0);
    check("R3", "async clear carry", int'(carry), 0);
    @(negedge clk); rst = 1'b0;
    run(10);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule